// File: doc/BRIEF.md
# Parallel Pixel Bus Capture and Word Packer

This block takes a parallel sample bus from an external image sensor or converter. It turns it into 64-bit words for the system side. The pixel clock, frame sync, line sync and data pins arrive asynchronously. They pass through a two-stage synchroniser on the system clock. A sample is taken when the synchronised pixel clock shows the configured active edge, but only while both frame sync and line sync are high.

Each sample is cut down to the configured width: 8, 10, 12, 14 or 16 bits. It is then placed into a lane of a 64-bit word. Eight-bit samples fill eight byte lanes. Wider samples fill four halfword lanes, each zero-extended, and the first sample always takes the lowest lane. When a frame ends with a word partly filled, that word is pushed with its unused lanes set to zero.

Finished words enter a 16-entry receive FIFO. The FIFO raises a flag once its fill level reaches a programmable threshold. It keeps a sticky overflow bit for words lost because the FIFO was full. A channel index counts the lines of a frame, wraps at a programmable maximum, and returns to zero at the start of each frame.

Top module: `pixbus_packer`

## Requirements
- R1: While `rst` is high at a clock edge, the block resets. After that edge, `fifo_level`, `thresh_flag`, `ovf_flag`, `chan_idx` and `rd_data` are all zero.
- R2: The active pixel clock edge depends on `cfg_fall_edge`. When it is 0, only low-to-high transitions of `pclk_in` take samples. When it is 1, only high-to-low transitions take samples.
- R3: A sample is captured only if `vsync_in` and `hsync_in` are both high together with the active pixel clock edge. Active edges at any other time add no data.
- R4: `cfg_width` selects the sample width. Codes 0, 1, 2, 3 and 4 mean 8, 10, 12, 14 and 16 bits, and codes 5 to 7 act as 16 bits. Data bits above the selected width are cleared before packing.
- R5: With code 0, eight samples make one word. Sample k of the word (k = 0..7) lands in bits 8k+7:8k.
- R6: With any other code, four samples make one word. Sample k (k = 0..3) lands in bits 16k+15:16k, and the upper bits of its lane are zero.
- R7: When `vsync_in` falls and the current word holds at least one sample, that word is pushed with its empty lanes at zero. If the current word is empty, nothing is pushed.
- R8: The FIFO holds 16 words, and `fifo_level` gives the number stored. A word completed by a pixel clock edge is counted in `fifo_level` after the fourth clock edge following the pin change. `rd_en` high at a clock edge pops one word when `fifo_level` is non-zero, and that word appears on `rd_data` after the same edge. At all other times `rd_data` holds its value.
- R9: `thresh_flag` is high exactly when `fifo_level` is at least the effective threshold. The effective threshold is `cfg_thresh`, except that 0 counts as 1 and values above 16 count as 16. The flag is updated at the same edge as the level.
- R10: A completed word that arrives while `fifo_level` is 16 is dropped, even if the same edge also pops a word, and `ovf_flag` is set. The flag stays set until an edge where `ovf_clr` is high and no word is being dropped.
- R11: `chan_idx` returns to 0 when `vsync_in` rises. Each fall of `hsync_in` while `vsync_in` is high advances it by one, and after `cfg_chan_max` it wraps to 0. The output changes on the third clock edge after the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_in | input | 1 | Asynchronous pixel clock pin |
| vsync_in | input | 1 | Frame-active sync pin |
| hsync_in | input | 1 | Line-active sync pin |
| pix_in | input | 16 | Sample data pins |
| cfg_fall_edge | input | 1 | 0 = rising capture edge, 1 = falling |
| cfg_width | input | 3 | Sample width code |
| cfg_thresh | input | 5 | FIFO fill threshold |
| cfg_chan_max | input | 3 | Last channel index before wrap |
| ovf_clr | input | 1 | Clears the overflow flag (write-one-to-clear) |
| rd_en | input | 1 | Pop one word from the FIFO |
| rd_data | output | 64 | Most recently popped word |
| fifo_level | output | 5 | Number of words stored |
| thresh_flag | output | 1 | Fill level at or above threshold |
| ovf_flag | output | 1 | Sticky overflow indicator |
| chan_idx | output | 3 | Current channel index |

## Verification
Byte-mode frames use data whose upper pin bits are set. This shows whether masking, lane order and the choice of byte lanes versus halfword lanes are correct. Falling-edge frames at 12-bit width, plus one frame each at 10, 14 and an out-of-range width code, show whether the wrong clock edge takes samples and whether the mask is correct for each code. Clock edges sent while line sync is low, and a frame that ends with three samples pending, show whether gating and flush padding work. Finally, a burst of 17 byte-mode words with no reads, followed by a clear pulse and a paced drain under changing thresholds, and a six-line frame with a small wrap count, exercise the overflow drop, the flag hold, the threshold comparison and the channel wrap.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  localparam int unsigned PIX_W = 16;

  typedef enum logic [2:0] {
    WID_8  = 3'd0,
    WID_10 = 3'd1,
    WID_12 = 3'd2,
    WID_14 = 3'd3,
    WID_16 = 3'd4
  } wid_e;

  // keep-mask for a width code; codes past WID_16 take the full bus
  function automatic logic [PIX_W-1:0] wid_mask(input logic [2:0] code);
    int bits;
    logic [PIX_W-1:0] m;
    bits = (code < 3'd4) ? 8 + 2 * int'(code) : int'(PIX_W);
    for (int i = 0; i < int'(PIX_W); i++) m[i] = (i < bits);
    return m;
  endfunction
endpackage

// File: rtl/pbp_sync.sv
module pbp_sync
  import pbp_pkg::*;
#(
  parameter int unsigned DW     = PIX_W,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall_sel,
  input  logic          pclk_in,
  input  logic          vs_in,
  input  logic          hs_in,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_s,
  output logic          vs_s,
  output logic          hs_s,
  output logic          smp_evt,
  output logic          vs_rise,
  output logic          vs_fall,
  output logic          hs_fall
);
  localparam int unsigned BUS_W = DW + 3;
  localparam int unsigned PC_B  = BUS_W - 1;
  localparam int unsigned VS_B  = BUS_W - 2;
  localparam int unsigned HS_B  = BUS_W - 3;

  logic [STAGES-1:0][BUS_W-1:0] stg;
  logic [2:0]                   ctl_d;
  logic [BUS_W-1:0]             tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg   <= '0;
      ctl_d <= '0;
    end else begin
      stg[0] <= {pclk_in, vs_in, hs_in, d_in};
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      ctl_d <= tail[PC_B -: 3];
    end
  end

  assign tail = stg[STAGES-1];
  assign d_s  = tail[DW-1:0];
  assign vs_s = tail[VS_B];
  assign hs_s = tail[HS_B];

  // edge flags from the last two synchronised samples of each control pin
  assign smp_evt = fall_sel ? (ctl_d[2] & ~tail[PC_B]) : (tail[PC_B] & ~ctl_d[2]);
  assign vs_rise = tail[VS_B] & ~ctl_d[1];
  assign vs_fall = ctl_d[1] & ~tail[VS_B];
  assign hs_fall = ctl_d[0] & ~tail[HS_B];
endmodule

// File: rtl/pbp_packer.sv
module pbp_packer
  import pbp_pkg::*;
#(
  parameter int unsigned DW     = PIX_W,
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        wid,
  input  logic              smp_evt,
  input  logic              vs_s,
  input  logic              hs_s,
  input  logic              vs_fall,
  input  logic [DW-1:0]     d_s,
  output logic              wr_vld,
  output logic [WORD_W-1:0] wr_word
);
  localparam int unsigned BYTE_LANES = WORD_W / 8;
  localparam int unsigned HALF_LANES = WORD_W / DW;
  localparam int unsigned CNT_W      = $clog2(BYTE_LANES);

  logic [WORD_W-1:0] acc_q, acc_n;
  logic [CNT_W-1:0]  cnt_q;
  logic [DW-1:0]     smp;
  logic              narrow, last, take;

  assign narrow = (wid_e'(wid) == WID_8);
  assign smp    = d_s & wid_mask(wid);
  assign take   = smp_evt & vs_s & hs_s;
  assign last   = narrow ? (cnt_q == CNT_W'(BYTE_LANES - 1))
                         : (cnt_q == CNT_W'(HALF_LANES - 1));

  always_comb begin
    acc_n = acc_q;
    if (narrow) acc_n[int'(cnt_q)*8 +: 8] = smp[7:0];
    else        acc_n[int'(cnt_q)*int'(DW) +: DW] = smp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      wr_vld  <= 1'b0;
      wr_word <= '0;
    end else begin
      wr_vld <= 1'b0;
      if (take) begin
        if (last) begin
          wr_vld  <= 1'b1;
          wr_word <= acc_n;
          acc_q   <= '0;
          cnt_q   <= '0;
        end else begin
          acc_q <= acc_n;
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (vs_fall && cnt_q != '0) begin
        wr_vld  <= 1'b1;
        wr_word <= acc_q;
        acc_q   <= '0;
        cnt_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/pbp_fifo.sv
module pbp_fifo #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_vld,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  input  logic              ovf_clr,
  input  logic [LVL_W-1:0]  thresh,
  output logic [WORD_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              thr_flag,
  output logic              ovf
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [LVL_W-1:0]  level_n, eff_thr;
  logic              full, empty, do_wr, do_rd;

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
  assign do_wr = wr_vld & ~full;
  assign do_rd = rd_en & ~empty;

  always_comb begin
    if (thresh == '0)                eff_thr = LVL_W'(1);
    else if (thresh > LVL_W'(DEPTH)) eff_thr = LVL_W'(DEPTH);
    else                             eff_thr = thresh;
  end

  always_comb begin
    case ({do_wr, do_rd})
      2'b10:   level_n = level + LVL_W'(1);
      2'b01:   level_n = level - LVL_W'(1);
      default: level_n = level;
    endcase
  end

  // storage port kept reset-free so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (do_rd) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      level    <= '0;
      thr_flag <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      level    <= level_n;
      thr_flag <= (level_n >= eff_thr);
      if (wr_vld && full) ovf <= 1'b1;
      else if (ovf_clr)   ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/pbp_chan.sv
module pbp_chan #(
  parameter int unsigned CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vs_s,
  input  logic            vs_rise,
  input  logic            hs_fall,
  input  logic [CH_W-1:0] max_idx,
  output logic [CH_W-1:0] chan
);
  always_ff @(posedge clk) begin
    if (rst || vs_rise)        chan <= '0;
    else if (hs_fall && vs_s)  chan <= (chan == max_idx) ? '0 : chan + 1'b1;
  end
endmodule

// File: rtl/pixbus_packer.sv
module pixbus_packer
  import pbp_pkg::*;
#(
  parameter int unsigned DW          = PIX_W,
  parameter int unsigned WORD_W      = 64,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned CH_W        = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LVL_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pclk_in,
  input  logic              vsync_in,
  input  logic              hsync_in,
  input  logic [DW-1:0]     pix_in,
  input  logic              cfg_fall_edge,
  input  logic [2:0]        cfg_width,
  input  logic [LVL_W-1:0]  cfg_thresh,
  input  logic [CH_W-1:0]   cfg_chan_max,
  input  logic              ovf_clr,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              thresh_flag,
  output logic              ovf_flag,
  output logic [CH_W-1:0]   chan_idx
);
  logic [DW-1:0]     d_s;
  logic              vs_s, hs_s, smp_evt, vs_rise, vs_fall, hs_fall;
  logic              wr_vld;
  logic [WORD_W-1:0] wr_word;

  pbp_sync #(.DW(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .fall_sel(cfg_fall_edge),
    .pclk_in(pclk_in), .vs_in(vsync_in), .hs_in(hsync_in), .d_in(pix_in),
    .d_s(d_s), .vs_s(vs_s), .hs_s(hs_s), .smp_evt(smp_evt),
    .vs_rise(vs_rise), .vs_fall(vs_fall), .hs_fall(hs_fall)
  );

  pbp_packer #(.DW(DW), .WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .wid(cfg_width), .smp_evt(smp_evt),
    .vs_s(vs_s), .hs_s(hs_s), .vs_fall(vs_fall), .d_s(d_s),
    .wr_vld(wr_vld), .wr_word(wr_word)
  );

  pbp_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_word(wr_word),
    .rd_en(rd_en), .ovf_clr(ovf_clr), .thresh(cfg_thresh),
    .rd_data(rd_data), .level(fifo_level), .thr_flag(thresh_flag), .ovf(ovf_flag)
  );

  pbp_chan #(.CH_W(CH_W)) u_chan (
    .clk(clk), .rst(rst), .vs_s(vs_s), .vs_rise(vs_rise),
    .hs_fall(hs_fall), .max_idx(cfg_chan_max), .chan(chan_idx)
  );
endmodule

// File: rtl/pixbus_packer_chk.sv
module pixbus_packer_chk #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned LVL_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              ovf_clr,
  input logic              rd_en,
  input logic [WORD_W-1:0] rd_data,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              thresh_flag,
  input logic              ovf_flag,
  input logic [CH_W-1:0]   chan_idx
);
  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(fifo_level) <= int'(DEPTH));

  // R8
  level_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_level != $past(fifo_level)) |->
      (int'(fifo_level) == int'($past(fifo_level)) + 1 ||
       int'(fifo_level) == int'($past(fifo_level)) - 1));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || fifo_level == '0) |=> $stable(rd_data));

  // R9
  thr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_level == '0) |-> !thresh_flag);

  // R10
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> int'($past(fifo_level)) == int'(DEPTH));

  // R11
  chan_step_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_idx != $past(chan_idx)) |->
      (chan_idx == '0 || int'(chan_idx) == int'($past(chan_idx)) + 1));
endmodule

bind pixbus_packer pixbus_packer_chk #(
  .WORD_W(WORD_W), .DEPTH(DEPTH), .CH_W(CH_W), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .ovf_clr(ovf_clr), .rd_en(rd_en), .rd_data(rd_data),
  .fifo_level(fifo_level), .thresh_flag(thresh_flag), .ovf_flag(ovf_flag),
  .chan_idx(chan_idx)
);

// File: tb/pixbus_packer_tb.sv
module pixbus_packer_tb;
  localparam int PW = 16;
  localparam int WW = 64;
  localparam int DP = 16;
  localparam int CW = 3;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          pclk_in = 1'b0, vsync_in = 1'b0, hsync_in = 1'b0;
  logic [PW-1:0] pix_in = '0;
  logic          cfg_fall_edge = 1'b0;
  logic [2:0]    cfg_width = 3'd0;
  logic [LW-1:0] cfg_thresh = 5'd1;
  logic [CW-1:0] cfg_chan_max = 3'd7;
  logic          ovf_clr = 1'b0, rd_en = 1'b0;
  logic [WW-1:0] rd_data;
  logic [LW-1:0] fifo_level;
  logic          thresh_flag, ovf_flag;
  logic [CW-1:0] chan_idx;

  pixbus_packer u_dut (
    .clk(clk), .rst(rst), .pclk_in(pclk_in), .vsync_in(vsync_in),
    .hsync_in(hsync_in), .pix_in(pix_in), .cfg_fall_edge(cfg_fall_edge),
    .cfg_width(cfg_width), .cfg_thresh(cfg_thresh), .cfg_chan_max(cfg_chan_max),
    .ovf_clr(ovf_clr), .rd_en(rd_en), .rd_data(rd_data), .fifo_level(fifo_level),
    .thresh_flag(thresh_flag), .ovf_flag(ovf_flag), .chan_idx(chan_idx)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic          h_pc [0:4];
  logic          h_vs [0:4];
  logic          h_hs [0:4];
  logic [PW-1:0] h_d  [0:4];
  logic [63:0]   m_q[$];
  logic [63:0]   m_acc, m_pk_word, m_rd;
  int            m_cnt, m_chan;
  bit            m_pk_vld, m_ovf, m_flag;

  function automatic int eff_thr(input int t);
    if (t == 0) return 1;
    if (t > DP) return DP;
    return t;
  endfunction

  function automatic logic [PW-1:0] keep_mask(input int code);
    int bits;
    bits = (code < 4) ? 8 + 2 * code : 16;
    return PW'((32'd1 << bits) - 1);
  endfunction

  always @(posedge clk) begin
    bit full_b, empty_b, evt, narrow;
    int lanes;
    logic [PW-1:0] v;
    if (rst) begin
      for (int k = 0; k < 5; k++) begin
        h_pc[k] = 1'b0; h_vs[k] = 1'b0; h_hs[k] = 1'b0; h_d[k] = '0;
      end
      m_q.delete();
      m_acc = '0; m_pk_word = '0; m_rd = '0;
      m_cnt = 0; m_chan = 0; m_pk_vld = 1'b0; m_ovf = 1'b0; m_flag = 1'b0;
    end else begin
      for (int k = 4; k > 0; k--) begin
        h_pc[k] = h_pc[k-1]; h_vs[k] = h_vs[k-1]; h_hs[k] = h_hs[k-1]; h_d[k] = h_d[k-1];
      end
      h_pc[0] = pclk_in; h_vs[0] = vsync_in; h_hs[0] = hsync_in; h_d[0] = pix_in;
      // storage stage
      full_b  = (m_q.size() == DP);
      empty_b = (m_q.size() == 0);
      if (rd_en && !empty_b) m_rd = m_q.pop_front();
      if (m_pk_vld && full_b) m_ovf = 1'b1;
      else begin
        if (m_pk_vld) m_q.push_back(m_pk_word);
        if (ovf_clr) m_ovf = 1'b0;
      end
      m_flag = (m_q.size() >= eff_thr(int'(cfg_thresh)));
      // packing stage (pins two and three edges back)
      m_pk_vld = 1'b0;
      evt    = cfg_fall_edge ? (h_pc[3] && !h_pc[2]) : (h_pc[2] && !h_pc[3]);
      narrow = (cfg_width == 3'd0);
      lanes  = narrow ? 8 : 4;
      if (evt && h_vs[2] && h_hs[2]) begin
        v = h_d[2] & keep_mask(int'(cfg_width));
        if (narrow) m_acc[m_cnt*8 +: 8] = v[7:0];
        else        m_acc[m_cnt*16 +: 16] = v;
        m_cnt++;
        if (m_cnt == lanes) begin
          m_pk_vld = 1'b1; m_pk_word = m_acc; m_acc = '0; m_cnt = 0;
        end
      end else if (h_vs[3] && !h_vs[2] && m_cnt != 0) begin
        m_pk_vld = 1'b1; m_pk_word = m_acc; m_acc = '0; m_cnt = 0;
      end
      // channel index
      if (h_vs[2] && !h_vs[3]) m_chan = 0;
      else if (h_hs[3] && !h_hs[2] && h_vs[2])
        m_chan = (m_chan == int'(cfg_chan_max)) ? 0 : m_chan + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "rd_data", rd_data, m_rd);
      chk("R8", "fifo_level", 64'(fifo_level), 64'(m_q.size()));
      chk("R9", "thresh_flag", 64'(thresh_flag), 64'(m_flag));
      chk("R10", "ovf_flag", 64'(ovf_flag), 64'(m_ovf));
      chk("R11", "chan_idx", 64'(chan_idx), 64'(m_chan));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pix(input logic [PW-1:0] d);
    pix_in = d;
    tick(2);
    pclk_in = ~pclk_in;
    tick(2);
    pclk_in = ~pclk_in;
    tick(1);
  endtask

  task automatic frame_on();
    vsync_in = 1'b1; tick(3);
  endtask
  task automatic frame_off();
    vsync_in = 1'b0; tick(6);
  endtask
  task automatic line_on();
    hsync_in = 1'b1; tick(2);
  endtask
  task automatic line_off();
    hsync_in = 1'b0; tick(3);
  endtask
  task automatic pop(input int n);
    rd_en = 1'b1; tick(n); rd_en = 1'b0; tick(2);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(1);
    // R1: reset state
    chk("R1", "reset level", 64'(fifo_level), 64'd0);
    chk("R1", "reset ovf", 64'(ovf_flag), 64'd0);
    chk("R1", "reset rd_data", rd_data, 64'd0);
    chk("R1", "reset chan", 64'(chan_idx), 64'd0);

    // R5 R4 R2: byte lanes, rising edge, upper pin bits set
    cur_req = "R5";
    cfg_width = 3'd0;
    frame_on(); line_on();
    for (int i = 0; i < 8; i++) pix(16'hA500 | PW'(8'h11 * (i + 1)));
    line_off();
    // R3: edges with line sync low add no data
    cur_req = "R3";
    for (int i = 0; i < 5; i++) pix(16'h00EE);
    frame_off();
    pop(1);
    chk("R5", "byte word", rd_data, 64'h8877665544332211);

    // R6 R2 R7: halfword lanes, falling edge, partial word flush
    cur_req = "R6";
    cfg_width = 3'd2;
    cfg_fall_edge = 1'b1; pclk_in = 1'b1; tick(4);
    frame_on(); line_on();
    pix(16'hFFFF); pix(16'h1234); pix(16'hF0A5); pix(16'h0ABC);
    cur_req = "R7";
    pix(16'h8001); pix(16'h7002); pix(16'h6003);
    line_off(); frame_off();
    pop(1);
    chk("R6", "halfword word", rd_data, 64'h0ABC_00A5_0234_0FFF);
    pop(1);
    chk("R7", "flushed word", rd_data, 64'h0000_0003_0002_0001);
    pop(1);
    chk("R8", "empty pop hold", rd_data, 64'h0000_0003_0002_0001);

    // R4: remaining width codes
    cur_req = "R4";
    cfg_fall_edge = 1'b0; pclk_in = 1'b0; tick(4);
    for (int c = 1; c < 6; c += 2) begin
      cfg_width = 3'(c);
      frame_on(); line_on();
      for (int i = 0; i < 4; i++) pix(16'hFFFF);
      line_off(); frame_off();
    end
    pop(3);

    // R9 R10: overflow burst, clear, paced drain with thresholds
    cur_req = "R10";
    cfg_width = 3'd0; cfg_thresh = 5'd16;
    frame_on(); line_on();
    for (int w = 0; w < 17; w++)
      for (int i = 0; i < 8; i++) pix(PW'(w * 8 + i));
    line_off(); frame_off();
    chk("R10", "overflow set", 64'(ovf_flag), 64'd1);
    tick(3);
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0; tick(1);
    chk("R10", "overflow cleared", 64'(ovf_flag), 64'd0);
    cur_req = "R9";
    cfg_thresh = 5'd0; tick(2);
    cfg_thresh = 5'd20; tick(2);
    cfg_thresh = 5'd3;
    for (int i = 0; i < 16; i++) pop(1);

    // R11: channel wrap and frame restart
    cur_req = "R11";
    cfg_chan_max = 3'd2;
    frame_on();
    for (int l = 0; l < 6; l++) begin line_on(); line_off(); end
    frame_off();
    frame_on();
    chk("R11", "chan after new frame", 64'(chan_idx), 64'd0);
    line_on(); line_off();
    frame_off();

    tick(4);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(60000 * 4);
    n_bad++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule